// File: doc/BRIEF.md
# Two-Handshake Serial Frame Transmitter

This block serialises one data word at a time onto an asynchronous serial line. The host first presents a word on a parallel bus and pulses a byte-ready handshake. The word is copied into a holding register and the block becomes busy. A second strobe, the transmit-start, later copies the held word into a frame shift register. The block then sends a start bit, the data bits least significant first, an even parity bit and a stop bit.

The two handshakes are independent, so a word can be staged well ahead of the moment it goes out. Bit timing comes from a baud tick input that is high for one clock per bit period. The frame advances only on ticked cycles. A three-state controller (idle, waiting, sending) drives the datapath through a small bundle of strobes. As the frame shift register shifts toward its least significant bit, it fills in from the top with stop-level ones. The line idles high whenever no frame is being sent.

Top module: `serial_frame_tx`

## Requirements
- R1: After reset the block is idle: busy is 0 and txOut is 1.
- R2: In idle, a high byteReady captures dataIn into the holding register, and busy reads 1 from the next cycle on. While byteReady is low, the block stays idle with busy 0.
- R3: In waiting, the block holds the staged word for any number of cycles while sendStart is low, keeping busy at 1 and txOut at 1.
- R4: A high sendStart in waiting starts the frame: from the next cycle txOut shows the start bit, which is 0.
- R5: The frame order on txOut is as follows. Position 0 is the start bit (0). Positions 1 through DATA_W carry data bit 0 through data bit DATA_W-1, in that order. Position DATA_W+1 is the parity bit and position DATA_W+2 is the stop bit (1). Position k is shown after k baud ticks counted from the frame start.
- R6: The parity bit is even parity: it equals the XOR of all data bits of the staged word.
- R7: A cycle with baudTick low does not advance the frame. Baud ticks in idle or waiting have no effect.
- R8: The cycle after the tick that ends the stop bit (the DATA_W+3-th tick of the frame), the block is idle again: busy is 0 and txOut is 1.
- R9: A byteReady pulse while busy is ignored. A word staged in waiting is sent unchanged, and a pulse during sending does not re-arm the block.
- R10: A sendStart pulse while idle is ignored: busy stays 0 and txOut stays 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| dataIn | input | DATA_W | Parallel word from the host |
| byteReady | input | 1 | Stage dataIn into the holding register (accepted only when idle) |
| sendStart | input | 1 | Start sending the staged word (accepted only when waiting) |
| baudTick | input | 1 | One-cycle-per-bit advance enable |
| txOut | output | 1 | Serial line, high when idle |
| busy | output | 1 | High while a word is staged or being sent |

## Verification
The bench builds the block with its default DATA_W of 8. At that width, all 256 data words can be sent through complete frames. Every start, data, parity and stop position is therefore compared against a frame built arithmetically in the bench, and every parity outcome is reached. Between ticks the bench inserts 0, 1 or 2 idle cycles, which shows that the frame holds still without a tick. Separate sequences stage a word for a long time under spurious ticks and handshakes, and pulse sendStart while idle.

// File: rtl/sftx_pkg.sv
package sftx_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_SEND = 2'd2
  } txState_e;

  // Strobes from the controller to the datapath
  typedef struct packed {
    logic loadHold;   // copy dataIn into the holding register
    logic loadShift;  // build the frame from the holding register
    logic start;      // frame begins: zero the bit counter
    logic shift;      // advance one bit, fill with stop level
    logic clear;      // frame done: zero the bit counter
  } txCtl_t;

endpackage

// File: rtl/sftx_dpath.sv
module sftx_dpath
  import sftx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [DATA_W-1:0] dataIn,
  input  txCtl_t            ctl,
  input  logic              sending,
  output logic              txOut,
  output logic              lastBit
);

  localparam int FRAME_W = DATA_W + 3;
  localparam int CNT_W   = $clog2(FRAME_W);
  localparam logic [CNT_W-1:0] LAST_POS = CNT_W'(FRAME_W - 1);

  logic [DATA_W-1:0]  holdReg;
  logic [FRAME_W-1:0] frameReg;
  logic [CNT_W-1:0]   bitCnt;
  logic               parityBit;

  assign parityBit = ^holdReg;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      holdReg <= '0;
    end else if (ctl.loadHold) begin
      holdReg <= dataIn;
    end
  end

  // Frame layout, LSB leaves first: start, data, parity, stop
  always_ff @(posedge clk) begin
    if (!rstN) begin
      frameReg <= '1;
    end else if (ctl.loadShift) begin
      frameReg <= {1'b1, parityBit, holdReg, 1'b0};
    end else if (ctl.shift) begin
      frameReg <= {1'b1, frameReg[FRAME_W-1:1]};
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      bitCnt <= '0;
    end else if (ctl.start || ctl.clear) begin
      bitCnt <= '0;
    end else if (ctl.shift) begin
      bitCnt <= bitCnt + CNT_W'(1);
    end
  end

  assign lastBit = (bitCnt == LAST_POS);
  assign txOut   = sending ? frameReg[0] : 1'b1;

endmodule

// File: rtl/sftx_ctrl.sv
module sftx_ctrl
  import sftx_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     byteReady,
  input  logic     sendStart,
  input  logic     baudTick,
  input  logic     lastBit,
  output txState_e state,
  output txCtl_t   ctl
);

  txState_e nextState;

  always_comb begin
    ctl       = '0;
    nextState = state;
    case (state)
      ST_IDLE: begin
        if (byteReady) begin
          ctl.loadHold = 1'b1;
          nextState    = ST_WAIT;
        end
      end
      ST_WAIT: begin
        if (sendStart) begin
          ctl.start     = 1'b1;
          ctl.loadShift = 1'b1;
          nextState     = ST_SEND;
        end
      end
      ST_SEND: begin
        if (baudTick) begin
          if (lastBit) begin
            ctl.clear = 1'b1;
            nextState = ST_IDLE;
          end else begin
            ctl.shift = 1'b1;
          end
        end
      end
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nextState;
  end

endmodule

// File: rtl/serial_frame_tx.sv
module serial_frame_tx
  import sftx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [DATA_W-1:0] dataIn,
  input  logic              byteReady,
  input  logic              sendStart,
  input  logic              baudTick,
  output logic              txOut,
  output logic              busy
);

  txState_e state;
  txCtl_t   ctl;
  logic     lastBit;
  logic     sending;

  assign sending = (state == ST_SEND);
  assign busy    = (state != ST_IDLE);

  sftx_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .byteReady (byteReady),
    .sendStart (sendStart),
    .baudTick  (baudTick),
    .lastBit   (lastBit),
    .state     (state),
    .ctl       (ctl)
  );

  sftx_dpath #(.DATA_W(DATA_W)) u_dpath (
    .clk     (clk),
    .rstN    (rstN),
    .dataIn  (dataIn),
    .ctl     (ctl),
    .sending (sending),
    .txOut   (txOut),
    .lastBit (lastBit)
  );

endmodule

// File: rtl/sftx_checker.sv
module sftx_checker
  import sftx_pkg::*;
(
  input logic     clk,
  input logic     rstN,
  input logic     byteReady,
  input logic     sendStart,
  input logic     baudTick,
  input logic     txOut,
  input logic     busy,
  input txState_e state
);

  // R1
  idle_line_high_chk: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> txOut);

  // R2
  stage_accept_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE && byteReady) |=> (busy && state == ST_WAIT));

  // R10
  idle_stay_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE && !byteReady) |=> !busy);

  // R3
  wait_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_WAIT && !sendStart) |=> (state == ST_WAIT && txOut));

  // R4
  start_bit_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_WAIT && sendStart) |=> (state == ST_SEND && !txOut));

  // R7
  no_tick_stall_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_SEND && !baudTick) |=> (state == ST_SEND && $stable(txOut)));

endmodule

bind serial_frame_tx sftx_checker u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .byteReady (byteReady),
  .sendStart (sendStart),
  .baudTick  (baudTick),
  .txOut     (txOut),
  .busy      (busy),
  .state     (state)
);

// File: tb/sim_serial_frame_tx.sv
`timescale 1ns/1ps
module sim_serial_frame_tx;

  localparam int DATA_W  = 8;
  localparam int FRAME_W = DATA_W + 3;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic [DATA_W-1:0] dataIn = '0;
  logic              byteReady = 1'b0;
  logic              sendStart = 1'b0;
  logic              baudTick = 1'b0;
  logic              txOut;
  logic              busy;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  serial_frame_tx #(.DATA_W(DATA_W)) u0 (
    .clk(clk), .rstN(rstN), .dataIn(dataIn), .byteReady(byteReady),
    .sendStart(sendStart), .baudTick(baudTick), .txOut(txOut), .busy(busy)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic expBit(input logic [DATA_W-1:0] w, input int pos);
    logic p;
    p = 1'b0;
    for (int j = 0; j < DATA_W; j++) p = p ^ w[j];
    if (pos == 0) return 1'b0;
    if (pos <= DATA_W) return w[pos-1];
    if (pos == DATA_W + 1) return p;
    return 1'b1;
  endfunction

  task automatic tickOnce();
    @(negedge clk) baudTick = 1'b1;
    @(negedge clk) baudTick = 1'b0;
  endtask

  task automatic stage(input logic [DATA_W-1:0] w);
    @(negedge clk) begin dataIn = w; byteReady = 1'b1; end
    @(negedge clk) byteReady = 1'b0;
    chk("R2 busy after stage", busy, 1);
    chk("R3 line high while waiting", txOut, 1);
  endtask

  task automatic startFrame();
    @(negedge clk) sendStart = 1'b1;
    @(negedge clk) sendStart = 1'b0;
    chk("R4 start bit", txOut, 0);
  endtask

  // Observe a full frame; gap idle cycles between ticks; optional busy pulse
  task automatic runFrame(input logic [DATA_W-1:0] w, input int gap, input bit poke);
    for (int pos = 0; pos < FRAME_W; pos++) begin
      if (pos == DATA_W + 1) chk("R6 parity bit", txOut, expBit(w, pos));
      else chk("R5 frame position", txOut, expBit(w, pos));
      for (int g = 0; g < gap; g++) begin
        @(negedge clk);
        chk("R7 hold without tick", txOut, expBit(w, pos));
      end
      if (poke && pos == 4) begin
        @(negedge clk) begin dataIn = ~w; byteReady = 1'b1; end
        @(negedge clk) byteReady = 1'b0;
        chk("R9 pulse while sending", txOut, expBit(w, pos));
      end
      tickOnce();
    end
    chk("R8 idle after frame busy", busy, 0);
    chk("R8 idle after frame line", txOut, 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1 reset busy", busy, 0);
    chk("R1 reset line", txOut, 1);

    // R10: start strobe and ticks while idle do nothing
    @(negedge clk) begin sendStart = 1'b1; baudTick = 1'b1; end
    @(negedge clk) begin sendStart = 1'b0; baudTick = 1'b0; end
    chk("R10 start ignored busy", busy, 0);
    chk("R10 start ignored line", txOut, 1);
    repeat (4) @(negedge clk);
    chk("R2 stays idle without byteReady", busy, 0);

    // Exhaustive sweep of words
    for (int w = 0; w < (1 << DATA_W); w++) begin
      stage(DATA_W'(w));
      startFrame();
      runFrame(DATA_W'(w), w % 3, (w % 16) == 0);
    end

    // Long staging with spurious ticks and a second handshake
    stage(8'h5A);
    for (int c = 0; c < 40; c++) begin
      @(negedge clk) baudTick = (c % 2 == 0);
      if (c == 20) begin dataIn = 8'hA5; byteReady = 1'b1; end
      else byteReady = 1'b0;
    end
    @(negedge clk) begin baudTick = 1'b0; byteReady = 1'b0; end
    chk("R3 still waiting busy", busy, 1);
    chk("R3 still waiting line", txOut, 1);
    startFrame();
    runFrame(8'h5A, 1, 1'b0);  // R9: staged word unchanged

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule